// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Generator

This block derives two system clocks from three free-running source clocks: an internal digitally controlled oscillator, a low-frequency crystal and a second crystal. The master clock can run from any of the three. The sub-system clock can run from the internal oscillator or the second crystal. Each output passes through a power-of-two divider and a stop gate. A handover scheme makes sure that changing the source never produces a runt pulse on either output.

An 8-bit control register and a small fault/status register sit on a byte-wide write/read port in the `clk_i` domain. A digital oscillator-fault input sets a sticky flag. That flag can raise a non-maskable interrupt request. While the flag is set, it forces the master clock off a failing crystal and onto the internal oscillator. The oscillators and the analog fault detector are outside the block.

Top module: `clk_gen_sys`

## Requirements
- R1: After reset both registers read 0x00, and both clocks run from the internal oscillator undivided.
- R2: The master source field (control bits 7:6) selects the internal oscillator for 0 or 1, the second crystal for 2 and the low-frequency crystal for 3.
- R3: The sub-system source bit (control bit 3) selects the internal oscillator when 0 and the second crystal when 1.
- R4: The master divide field (bits 5:4) and the sub-system divide field (bits 2:1) divide by 1, 2, 4 or 8 for codes 0 to 3. When a divide setting changes, the divider counter restarts its cycle.
- R5: A write with `addr_i`=0 loads the control register, and reading `addr_i`=0 returns it unchanged.
- R6: On a source change, the output finishes its current cycle up to the next rising edge and holds high until a rising edge of the new source. No output pulse is shorter than the shortest source half period, and at most one source is enabled at a time.
- R7: `cpu_off_i`=1 stops `mclk_o` low and `smclk_o` keeps running. `smclk_off_i`=1 stops `smclk_o` low. Clearing either input resumes the output at its configured rate.
- R8: A high level on `osc_fault_i` sets the fault flag (status bit 0), which stays set until a status write (`addr_i`=1) with bit 0 = 0. Status bit 1 is the interrupt enable, and `nmi_o` is high while both bits are set.
- R9: While the fault flag is set, master source 2 (and source 3 when `lfxt_hf_i`=1) is replaced by the internal oscillator. Source 3 with `lfxt_hf_i`=0 is not replaced.
- R10: `rosc_ext_o` follows control bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = control register, 1 = fault/status register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| dco_clk_i | input | 1 | Internal oscillator clock |
| lfxt_clk_i | input | 1 | Low-frequency crystal clock |
| xt2_clk_i | input | 1 | Second crystal clock |
| lfxt_hf_i | input | 1 | Low-frequency crystal running in high-frequency mode |
| osc_fault_i | input | 1 | Oscillator fault, asynchronous level |
| cpu_off_i | input | 1 | Stop request for the master clock |
| smclk_off_i | input | 1 | Stop request for the sub-system clock |
| mclk_o | output | 1 | Master clock |
| smclk_o | output | 1 | Sub-system clock |
| rosc_ext_o | output | 1 | External-resistor enable |
| nmi_o | output | 1 | Fault interrupt request |

## Verification
Register readback is combinational, so it is sampled 1 ns after the falling edge that follows a write. The flag and `nmi_o` follow `osc_fault_i` within three `clk_i` cycles. A clock output settles only after two old-source edges, two new-source edges and two divider-domain edges. For that reason the bench waits 2.5 us after every configuration change, far longer than the slowest handover at divide by 8 on the 30 ns source. It then measures the period between the last two rising edges seen in a 1.5 us window and requires at least two edges in that window. A separate monitor times every pulse during source switches and counts any pulse shorter than 3.9 ns.

// File: rtl/clk_gen_pkg.sv
package clk_gen_pkg;
  localparam int N_MSRC = 3;
  localparam int N_SSRC = 2;
  localparam int DIV_W  = 2;
  localparam int M_DCO  = 0;
  localparam int M_LFXT = 1;
  localparam int M_XT2  = 2;

  typedef struct packed {
    logic [1:0]       msel;
    logic [DIV_W-1:0] mdiv;
    logic             ssel;
    logic [DIV_W-1:0] sdiv;
    logic             rext;
  } ctrl_t;
endpackage

// File: rtl/clk_cfg_regs.sv
module clk_cfg_regs
  import clk_gen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       osc_fault_i,
  output ctrl_t      ctrl_o,
  output logic       flag_o,
  output logic       ie_o
);
  logic [7:0] ctrl_q;
  logic       flag_q, ie_q, fault_s1, fault_s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      fault_s1 <= 1'b0;
      fault_s2 <= 1'b0;
    end else begin
      fault_s1 <= osc_fault_i;
      fault_s2 <= fault_s1;
      if (wr_en_i && !addr_i) ctrl_q <= wdata_i;
      if (wr_en_i && addr_i)  ie_q   <= wdata_i[1];
      // set wins over a clear in the same cycle
      if (fault_s2)                               flag_q <= 1'b1;
      else if (wr_en_i && addr_i && !wdata_i[0])  flag_q <= 1'b0;
    end
  end

  assign ctrl_o  = ctrl_t'(ctrl_q);
  assign flag_o  = flag_q;
  assign ie_o    = ie_q;
  assign rdata_o = addr_i ? {6'b0, ie_q, flag_q} : ctrl_q;

  // R5
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i) |=> (ctrl_q == $past(wdata_i)));

  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_s2 |=> flag_q);

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_en_i && addr_i && !wdata_i[0])) |=> flag_q);
endmodule

// File: rtl/clk_glitchless_mux.sv
module clk_glitchless_mux #(
  parameter int N_SRC       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] clk_src_i,
  input  logic [N_SRC-1:0] sel_oh_i,
  output logic             clk_o
);
  logic [N_SRC-1:0] en;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   req;
    // ask for the source only once every other source is released
    assign req = sel_oh_i[k] & ~|(en & ~(N_SRC'(1) << k));
    always_ff @(posedge clk_src_i[k] or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], req};
    end
    assign en[k] = sync_q[SYNC_STAGES-1];
  end

  // enables change only while their own clock is high, so the output idles high
  assign clk_o = &(clk_src_i | ~en);

  always_comb begin
    if (rst_ni) begin
      // R6
      one_src_chk: assert ($onehot0(en));
    end
  end
endmodule

// File: rtl/clk_div_gate.sv
module clk_div_gate #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             off_i,
  output logic             clk_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] div_s1, div_s2, div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             off_s, gate_q, div_clk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_s1 <= '0;
      div_s2 <= '0;
      div_q  <= '0;
      cnt_q  <= '1;
      off_s  <= 1'b0;
    end else begin
      div_s1 <= div_i;
      div_s2 <= div_s1;
      off_s  <= off_i;
      if (div_s2 != div_q) begin
        div_q <= div_s2;
        cnt_q <= '1;          // all high: next edge starts a fresh cycle
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign div_clk = (div_q == '0) ? clk_i : cnt_q[div_q - DIV_W'(1)];

  always_ff @(negedge div_clk or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= ~off_s;
  end

  assign clk_o = div_clk & gate_q;
endmodule

// File: rtl/clk_gen_sys.sv
module clk_gen_sys
  import clk_gen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       dco_clk_i,
  input  logic       lfxt_clk_i,
  input  logic       xt2_clk_i,
  input  logic       lfxt_hf_i,
  input  logic       osc_fault_i,
  input  logic       cpu_off_i,
  input  logic       smclk_off_i,
  output logic       mclk_o,
  output logic       smclk_o,
  output logic       rosc_ext_o,
  output logic       nmi_o
);
  ctrl_t              ctrl;
  logic               flag, ie, fallback;
  logic [N_MSRC-1:0]  m_req;
  logic [N_SSRC-1:0]  s_req;
  logic               m_raw, s_raw;

  clk_cfg_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .osc_fault_i,
    .ctrl_o(ctrl), .flag_o(flag), .ie_o(ie)
  );

  assign fallback = flag && ((ctrl.msel == 2'd2) || (ctrl.msel == 2'd3 && lfxt_hf_i));

  always_comb begin
    m_req = '0;
    if (fallback || !ctrl.msel[1]) m_req[M_DCO]  = 1'b1;
    else if (ctrl.msel == 2'd2)    m_req[M_XT2]  = 1'b1;
    else                           m_req[M_LFXT] = 1'b1;
  end
  assign s_req = ctrl.ssel ? 2'b10 : 2'b01;

  clk_glitchless_mux #(.N_SRC(N_MSRC)) u_mmux (
    .rst_ni, .clk_src_i({xt2_clk_i, lfxt_clk_i, dco_clk_i}), .sel_oh_i(m_req), .clk_o(m_raw)
  );
  clk_glitchless_mux #(.N_SRC(N_SSRC)) u_smux (
    .rst_ni, .clk_src_i({xt2_clk_i, dco_clk_i}), .sel_oh_i(s_req), .clk_o(s_raw)
  );

  clk_div_gate #(.DIV_W(DIV_W)) u_mdiv (
    .clk_i(m_raw), .rst_ni, .div_i(ctrl.mdiv), .off_i(cpu_off_i), .clk_o(mclk_o)
  );
  clk_div_gate #(.DIV_W(DIV_W)) u_sdiv (
    .clk_i(s_raw), .rst_ni, .div_i(ctrl.sdiv), .off_i(smclk_off_i), .clk_o(smclk_o)
  );

  assign rosc_ext_o = ctrl.rext;
  assign nmi_o      = flag & ie;

  // R9
  fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && ctrl.msel == 2'd2) |-> (m_req == N_MSRC'(1)));
endmodule

// File: tb/clk_gen_sys_test.sv
`timescale 1ns/1ps
module clk_gen_sys_test;
  localparam realtime P_DCO = 8.0, P_LF = 30.0, P_XT2 = 14.0;
  localparam logic [7:0] VEC [0:5] = '{8'h00, 8'h5C, 8'hA7, 8'hFD, 8'hC8, 8'h82};

  logic clk = 0, rst_n = 0, wr_en = 0, addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic dco = 0, lf = 0, xt2 = 0, hf = 0, fault = 0, cpu_off = 0, s_off = 0;
  logic mclk, smclk, rext, nmi;
  int checks = 0, fails = 0, m_cnt = 0, s_cnt = 0, glitches = 0;
  bit g_en = 0;
  realtime m_last = 0, m_per = 0, s_last = 0, s_per = 0, m_edge = 0, s_edge = 0;

  always #10 clk = ~clk;
  always #(P_DCO/2) dco = ~dco;
  always #(P_LF/2)  lf  = ~lf;
  always #(P_XT2/2) xt2 = ~xt2;

  clk_gen_sys uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .dco_clk_i(dco), .lfxt_clk_i(lf), .xt2_clk_i(xt2), .lfxt_hf_i(hf),
    .osc_fault_i(fault), .cpu_off_i(cpu_off), .smclk_off_i(s_off), .mclk_o(mclk),
    .smclk_o(smclk), .rosc_ext_o(rext), .nmi_o(nmi)
  );

  always @(posedge mclk)  begin m_per = $realtime - m_last; m_last = $realtime; m_cnt++; end
  always @(posedge smclk) begin s_per = $realtime - s_last; s_last = $realtime; s_cnt++; end
  always @(mclk)  begin if (g_en && ($realtime - m_edge) < 3.9) glitches++; m_edge = $realtime; end
  always @(smclk) begin if (g_en && ($realtime - s_edge) < 3.9) glitches++; s_edge = $realtime; end

  function automatic realtime exp_m(input logic [7:0] c, input bit flag, input bit hfm);
    realtime p;
    case (c[7:6])
      2'd2:    p = flag ? P_DCO : P_XT2;
      2'd3:    p = (flag && hfm) ? P_DCO : P_LF;
      default: p = P_DCO;
    endcase
    return p * (1 << c[5:4]);
  endfunction

  function automatic realtime exp_s(input logic [7:0] c);
    return (c[3] ? P_XT2 : P_DCO) * (1 << c[2:1]);
  endfunction

  task automatic chk(input string req, input bit ok, input realtime got, input realtime exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0.1f expected %0.1f", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic meas(input string req, input realtime em, input realtime es);
    int m0, s0;
    #2500;
    m0 = m_cnt; s0 = s_cnt;
    #1500;
    chk({req, " mclk"},  (m_cnt - m0 >= 2) && (m_per > em - 0.5) && (m_per < em + 0.5), m_per, em);
    chk({req, " smclk"}, (s_cnt - s0 >= 2) && (s_per > es - 0.5) && (s_per < es + 0.5), s_per, es);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int m0, s0;
    #55 rst_n = 1;

    // R1 reset state
    rd(0, d); chk("R1 ctrl reset", d == 8'h00, d, 0);
    rd(1, d); chk("R1 status reset", d == 8'h00, d, 0);
    meas("R1", P_DCO, P_DCO);

    // R2 R3 R4 R5 R10 vector walk
    foreach (VEC[i]) begin
      wr(0, VEC[i]);
      rd(0, d); chk("R5 readback", d == VEC[i], d, VEC[i]);
      chk("R10 rosc_ext", rext == VEC[i][0], rext, VEC[i][0]);
      meas("R2/R3/R4", exp_m(VEC[i], 0, 0), exp_s(VEC[i]));
    end

    // R6 source switching with no division
    g_en = 1;
    foreach (VEC[i]) begin
      wr(0, {i[1:0], 2'b00, i[0], 3'b000});
      #1500;
    end
    wr(0, 8'h00); #1500;
    g_en = 0;
    chk("R6 no runt pulse", glitches == 0, glitches, 0);

    // R7 stop inputs
    wr(0, 8'h00); #2500;
    cpu_off = 1; #500;
    m0 = m_cnt; s0 = s_cnt; #1000;
    chk("R7 mclk stopped", (m_cnt == m0) && (mclk == 0), m_cnt - m0, 0);
    chk("R7 smclk running", s_cnt - s0 > 50, s_cnt - s0, 125);
    s_off = 1; #500;
    s0 = s_cnt; #1000;
    chk("R7 smclk stopped", (s_cnt == s0) && (smclk == 0), s_cnt - s0, 0);
    cpu_off = 0; s_off = 0;
    meas("R7 resume", P_DCO, P_DCO);

    // R8 R9 fault handling
    wr(0, 8'h80);
    wr(1, 8'h03);
    fault = 1; #100 fault = 0;
    rd(1, d); chk("R8 flag set", d == 8'h03, d, 8'h03);
    chk("R8 nmi", nmi == 1, nmi, 1);
    meas("R9 fallback xt2", exp_m(8'h80, 1, 0), P_DCO);
    wr(1, 8'h03);
    rd(1, d); chk("R8 flag kept on bit0=1", d == 8'h03, d, 8'h03);
    wr(1, 8'h02);
    rd(1, d); chk("R8 flag cleared", d == 8'h02, d, 8'h02);
    chk("R8 nmi cleared", nmi == 0, nmi, 0);
    meas("R9 xt2 restored", P_XT2, P_DCO);

    wr(0, 8'hC0); hf = 0;
    fault = 1; #100 fault = 0;
    meas("R9 lf mode kept", exp_m(8'hC0, 1, 0), P_DCO);
    hf = 1;
    meas("R9 hf mode fallback", exp_m(8'hC0, 1, 1), P_DCO);
    wr(1, 8'h00);
    rd(1, d); chk("R8 clear and disable", d == 8'h00, d, 0);
    fault = 1; #100 fault = 0;
    rd(1, d); chk("R8 flag set with irq off", d == 8'h01, d, 8'h01);
    chk("R8 nmi masked", nmi == 0, nmi, 0);

    finish_run();
  end
endmodule